// File: doc/BRIEF.md
# Single-Entry Translation Cache

This block caches exactly one virtual-to-physical translation next to a page-table walker. The walker writes a completed translation into it, and the address path asks it combinationally whether a given address-space identifier and virtual address are already covered. The cached page may be a 4 KiB base page or a larger page. Its size follows from the walk depth stored with the entry: 12 offset bits plus 9 bits for each level above the bottom.

Besides lookup, three operations change the entry. A fill installs a new translation and discards the old one. A rewrite swaps only the stored 64-bit PTE, which is how accessed and dirty updates land in the cache. A flush empties the entry when it passes an optional address-space filter and an optional address filter. Lookup is purely combinational and reflects the entry as updated by the last clock edge.

Top module: `tlb1_cache`

## Requirements
- R1: After reset, and after any later reset pulse, the entry is empty and every lookup reports `lk_hit` = 0.
- R2: A fill replaces the entry unconditionally. From the next cycle, a lookup with the filled ID and address hits and returns the filled PTE, PTE address, level and global flag.
- R3: A valid entry with the global flag clear hits only when `lk_asid` equals the stored ID. With the global flag set, the ID is not compared.
- R4: The tag compare ignores virtual-address bits [11+9*level:0]. A difference in any higher bit of the 39-bit address gives a miss.
- R5: On a hit, `lk_paddr` takes the filled physical address with bits [11+9*level:0] cleared, ORed with the same low bits of `lk_vaddr`.
- R6: On a hit, `lk_idx` is 0.
- R7: A rewrite on a valid entry replaces only the stored PTE. All other fields stay unchanged. A rewrite on an empty entry leaves it empty.
- R8: A flush with both filters off empties the entry.
- R9: A flush with the ID filter on matches only a non-global entry whose stored ID equals `flush_asid`. A global entry survives it.
- R10: A flush with the address filter on matches when `flush_vaddr` lies in the cached page, using the same masked compare as lookup.
- R11: A flush whose filters do not all match leaves the entry and its lookup result unchanged.
- R12: In a single cycle, fill takes precedence over flush, and flush takes precedence over rewrite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_asid | input | 16 | Lookup address-space ID |
| lk_vaddr | input | 39 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | 1 | Index of the hitting entry (always 0) |
| lk_paddr | output | 56 | Translated physical address |
| lk_pte | output | 64 | Stored PTE |
| lk_pte_addr | output | 56 | Stored physical address of the PTE |
| lk_level | output | 2 | Stored level |
| lk_global | output | 1 | Stored global flag |
| fill_en | input | 1 | Install a new entry |
| fill_asid | input | 16 | Fill ID |
| fill_global | input | 1 | Fill global flag |
| fill_vaddr | input | 39 | Fill virtual address |
| fill_paddr | input | 56 | Fill physical address |
| fill_pte | input | 64 | Fill PTE |
| fill_pte_addr | input | 56 | Fill PTE physical address |
| fill_level | input | 2 | Fill level (0 = 4 KiB) |
| upd_en | input | 1 | Rewrite the stored PTE |
| upd_pte | input | 64 | Replacement PTE |
| flush_en | input | 1 | Flush request |
| flush_use_asid | input | 1 | Apply the ID filter |
| flush_asid | input | 16 | Flush ID |
| flush_use_addr | input | 1 | Apply the address filter |
| flush_vaddr | input | 39 | Flush virtual address |

## Verification
Lookups run against a level-1 entry with five patterns: the exact address, an address with every in-page bit flipped, a flip of the lowest tag bit, a flip of the top address bit, and a wrong ID. The first two separate in-page bits from tag bits and exercise the offset merge in the physical result. The last three show that each compare term alone can force a miss. Level-0 and level-2 fills then move the page boundary one bit at a time on either side. Flushes pair matching and non-matching filters against global and non-global entries, and same-cycle fill/flush and flush/rewrite pairs settle precedence.

// File: rtl/tlb1_pkg.sv
// Package: default geometry and the entry-update operation code for the
// single-entry translation cache. Assumes a three-level, 9-bit-per-level
// walk over 4 KiB base pages.
package tlb1_pkg;
    localparam int ASID_W_D     = 16;
    localparam int VA_W_D       = 39;
    localparam int PA_W_D       = 56;
    localparam int PTE_W_D      = 64;
    localparam int LEVELS_D     = 3;
    localparam int PAGE_BITS_D  = 12;
    localparam int LEVEL_BITS_D = 9;

    // Operation applied to the entry at the next clock edge
    typedef enum logic [1:0] {
        ENT_HOLD    = 2'd0,
        ENT_FILL    = 2'd1,
        ENT_FLUSH   = 2'd2,
        ENT_REWRITE = 2'd3
    } ent_op_e;
endpackage

// File: rtl/tlb1_va_mask.sv
// Page-offset mask generator: sets bit i when i lies inside a page of the
// given level (i < PAGE_BITS + LEVEL_BITS*level). Purely combinational.
// Assumes level never exceeds the walk depth; a larger value only widens
// the mask toward all ones.
module tlb1_va_mask #(
    parameter int VA_W       = 39,
    parameter int LVL_W      = 2,
    parameter int PAGE_BITS  = 12,
    parameter int LEVEL_BITS = 9
) (
    input  logic [LVL_W-1:0] level,
    output logic [VA_W-1:0]  mask
);
    logic [31:0] span;

    // Number of in-page bits for this level
    always_comb span = 32'(PAGE_BITS) + 32'(LEVEL_BITS) * 32'(level);

    for (genvar i = 0; i < VA_W; i++) begin : g_bit
        assign mask[i] = (32'(i) < span);
    end
endmodule

// File: rtl/tlb1_tag_cmp.sv
// Masked virtual-address compare: equal when the two addresses agree on
// every bit the mask leaves clear. Shared by lookup and flush paths.
module tlb1_tag_cmp #(
    parameter int VA_W = 39
) (
    input  logic [VA_W-1:0] a,
    input  logic [VA_W-1:0] b,
    input  logic [VA_W-1:0] ign_mask,
    output logic            equal
);
    // Any differing bit outside the ignored region breaks the match
    always_comb equal = ~|((a ^ b) & ~ign_mask);
endmodule

// File: rtl/tlb1_entry_reg.sv
// Entry storage: holds the one cached translation. Applies exactly one
// operation per cycle as chosen by the caller. Stores the page mask at
// fill time and pre-clears the in-page bits of the physical base.
// Assumes PA_W >= VA_W.
module tlb1_entry_reg
    import tlb1_pkg::*;
#(
    parameter int ASID_W = 16,
    parameter int VA_W   = 39,
    parameter int PA_W   = 56,
    parameter int PTE_W  = 64,
    parameter int LVL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ent_op_e           op,
    input  logic [ASID_W-1:0] in_asid,
    input  logic              in_global,
    input  logic [VA_W-1:0]   in_vaddr,
    input  logic [PA_W-1:0]   in_paddr,
    input  logic [PTE_W-1:0]  in_pte,
    input  logic [PA_W-1:0]   in_pte_addr,
    input  logic [LVL_W-1:0]  in_level,
    input  logic [VA_W-1:0]   in_mask,
    input  logic [PTE_W-1:0]  new_pte,
    output logic              e_valid,
    output logic [ASID_W-1:0] e_asid,
    output logic              e_global,
    output logic [VA_W-1:0]   e_vtag,
    output logic [PA_W-1:0]   e_pbase,
    output logic [PTE_W-1:0]  e_pte,
    output logic [PA_W-1:0]   e_pte_addr,
    output logic [LVL_W-1:0]  e_level,
    output logic [VA_W-1:0]   e_mask
);
    localparam int PAD_W = PA_W - VA_W;

    logic [PA_W-1:0] pmask;

    // Widen the page mask to physical width
    always_comb pmask = {{PAD_W{1'b0}}, in_mask};

    // Valid flag: set by fill, cleared by flush or reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_valid <= 1'b0;
        end else if (op == ENT_FILL) begin
            e_valid <= 1'b1;
        end else if (op == ENT_FLUSH) begin
            e_valid <= 1'b0;
        end
    end

    // Translation fields: written only on fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_asid     <= '0;
            e_global   <= 1'b0;
            e_vtag     <= '0;
            e_pbase    <= '0;
            e_pte_addr <= '0;
            e_level    <= '0;
            e_mask     <= '0;
        end else if (op == ENT_FILL) begin
            e_asid     <= in_asid;
            e_global   <= in_global;
            e_vtag     <= in_vaddr & ~in_mask;
            e_pbase    <= in_paddr & ~pmask;
            e_pte_addr <= in_pte_addr;
            e_level    <= in_level;
            e_mask     <= in_mask;
        end
    end

    // PTE bits: written on fill or on in-place rewrite
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_pte <= '0;
        end else if (op == ENT_FILL) begin
            e_pte <= in_pte;
        end else if (op == ENT_REWRITE) begin
            e_pte <= new_pte;
        end
    end
endmodule

// File: rtl/tlb1_cache.sv
// Single-entry translation cache top. Combinational lookup by ID and
// virtual address over a page whose size follows the stored level.
// Precedence per cycle: fill, then flush, then PTE rewrite. Assumes
// PA_W >= VA_W and a level below LEVELS.
module tlb1_cache
    import tlb1_pkg::*;
#(
    parameter int ASID_W     = ASID_W_D,
    parameter int VA_W       = VA_W_D,
    parameter int PA_W       = PA_W_D,
    parameter int PTE_W      = PTE_W_D,
    parameter int LEVELS     = LEVELS_D,
    parameter int PAGE_BITS  = PAGE_BITS_D,
    parameter int LEVEL_BITS = LEVEL_BITS_D,
    localparam int LVL_W     = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VA_W-1:0]   lk_vaddr,
    output logic              lk_hit,
    output logic              lk_idx,
    output logic [PA_W-1:0]   lk_paddr,
    output logic [PTE_W-1:0]  lk_pte,
    output logic [PA_W-1:0]   lk_pte_addr,
    output logic [LVL_W-1:0]  lk_level,
    output logic              lk_global,
    input  logic              fill_en,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic              fill_global,
    input  logic [VA_W-1:0]   fill_vaddr,
    input  logic [PA_W-1:0]   fill_paddr,
    input  logic [PTE_W-1:0]  fill_pte,
    input  logic [PA_W-1:0]   fill_pte_addr,
    input  logic [LVL_W-1:0]  fill_level,
    input  logic              upd_en,
    input  logic [PTE_W-1:0]  upd_pte,
    input  logic              flush_en,
    input  logic              flush_use_asid,
    input  logic [ASID_W-1:0] flush_asid,
    input  logic              flush_use_addr,
    input  logic [VA_W-1:0]   flush_vaddr
);
    localparam int PAD_W = PA_W - VA_W;

    logic              e_valid;
    logic [ASID_W-1:0] e_asid;
    logic              e_global;
    logic [VA_W-1:0]   e_vtag;
    logic [PA_W-1:0]   e_pbase;
    logic [PTE_W-1:0]  e_pte;
    logic [PA_W-1:0]   e_pte_addr;
    logic [LVL_W-1:0]  e_level;
    logic [VA_W-1:0]   e_mask;
    logic [VA_W-1:0]   fill_mask;
    logic              lk_tag_eq;
    logic              fl_tag_eq;
    logic              fl_asid_ok;
    logic              fl_addr_ok;
    logic              fl_match;
    ent_op_e           op;

    tlb1_va_mask #(
        .VA_W       (VA_W),
        .LVL_W      (LVL_W),
        .PAGE_BITS  (PAGE_BITS),
        .LEVEL_BITS (LEVEL_BITS)
    ) u_fill_mask (
        .level (fill_level),
        .mask  (fill_mask)
    );

    tlb1_tag_cmp #(.VA_W(VA_W)) u_lk_cmp (
        .a        (lk_vaddr),
        .b        (e_vtag),
        .ign_mask (e_mask),
        .equal    (lk_tag_eq)
    );

    tlb1_tag_cmp #(.VA_W(VA_W)) u_fl_cmp (
        .a        (flush_vaddr),
        .b        (e_vtag),
        .ign_mask (e_mask),
        .equal    (fl_tag_eq)
    );

    // Flush filter: absent filters match anything, ID never matches global
    always_comb begin
        fl_asid_ok = !flush_use_asid || (!e_global && (flush_asid == e_asid));
        fl_addr_ok = !flush_use_addr || fl_tag_eq;
        fl_match   = e_valid && fl_asid_ok && fl_addr_ok;
    end

    // Operation select with fixed precedence fill > flush > rewrite
    always_comb begin
        if (fill_en)
            op = ENT_FILL;
        else if (flush_en && fl_match)
            op = ENT_FLUSH;
        else if (upd_en && e_valid)
            op = ENT_REWRITE;
        else
            op = ENT_HOLD;
    end

    tlb1_entry_reg #(
        .ASID_W (ASID_W),
        .VA_W   (VA_W),
        .PA_W   (PA_W),
        .PTE_W  (PTE_W),
        .LVL_W  (LVL_W)
    ) u_entry (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .in_asid     (fill_asid),
        .in_global   (fill_global),
        .in_vaddr    (fill_vaddr),
        .in_paddr    (fill_paddr),
        .in_pte      (fill_pte),
        .in_pte_addr (fill_pte_addr),
        .in_level    (fill_level),
        .in_mask     (fill_mask),
        .new_pte     (upd_pte),
        .e_valid     (e_valid),
        .e_asid      (e_asid),
        .e_global    (e_global),
        .e_vtag      (e_vtag),
        .e_pbase     (e_pbase),
        .e_pte       (e_pte),
        .e_pte_addr  (e_pte_addr),
        .e_level     (e_level),
        .e_mask      (e_mask)
    );

    // Lookup result: hit qualification and offset merge into the base
    always_comb begin
        lk_hit      = e_valid && lk_tag_eq && (e_global || (lk_asid == e_asid));
        lk_idx      = 1'b0;
        lk_paddr    = e_pbase | {{PAD_W{1'b0}}, lk_vaddr & e_mask};
        lk_pte      = e_pte;
        lk_pte_addr = e_pte_addr;
        lk_level    = e_level;
        lk_global   = e_global;
    end
endmodule

// File: rtl/tlb1_cache_chk.sv
// Checker for tlb1_cache: port-level temporal properties, bound into every
// instance of the top module.
module tlb1_cache_chk #(
    parameter int ASID_W = 16,
    parameter int VA_W   = 39,
    parameter int PTE_W  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ASID_W-1:0] lk_asid,
    input logic [VA_W-1:0]   lk_vaddr,
    input logic              lk_hit,
    input logic [PTE_W-1:0]  lk_pte,
    input logic              fill_en,
    input logic [ASID_W-1:0] fill_asid,
    input logic              fill_global,
    input logic [VA_W-1:0]   fill_vaddr,
    input logic              upd_en,
    input logic [PTE_W-1:0]  upd_pte,
    input logic              flush_en,
    input logic              flush_use_asid,
    input logic              flush_use_addr
);
    // First cycle out of reset: entry must be empty
    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !lk_hit);

    // Looking up exactly what was just filled must hit
    assert_fill_hits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (lk_asid != $past(fill_asid) || lk_vaddr != $past(fill_vaddr) || lk_hit));

    // Non-global entry never hits under a different ID
    assert_asid_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !fill_global) |=> (lk_asid == $past(fill_asid) || !lk_hit));

    // Rewrite on a live entry lands the new PTE
    assert_rewrite_pte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && lk_hit && !fill_en && !flush_en) |=> (lk_pte == $past(upd_pte)));

    // Unfiltered flush always empties the entry
    assert_flush_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_en && !flush_use_asid && !flush_use_addr && !fill_en) |=> !lk_hit);
endmodule

bind tlb1_cache tlb1_cache_chk #(
    .ASID_W (ASID_W),
    .VA_W   (VA_W),
    .PTE_W  (PTE_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .lk_asid        (lk_asid),
    .lk_vaddr       (lk_vaddr),
    .lk_hit         (lk_hit),
    .lk_pte         (lk_pte),
    .fill_en        (fill_en),
    .fill_asid      (fill_asid),
    .fill_global    (fill_global),
    .fill_vaddr     (fill_vaddr),
    .upd_en         (upd_en),
    .upd_pte        (upd_pte),
    .flush_en       (flush_en),
    .flush_use_asid (flush_use_asid),
    .flush_use_addr (flush_use_addr)
);

// File: tb/tlb1_cache_tb.sv
`timescale 1ns/1ps
// Bench for tlb1_cache: a vector table of lookups against one level-1
// entry, then directed tests for reset, rewrite, flush and precedence.
module tlb1_cache_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] lk_asid = '0;
    logic [38:0] lk_vaddr = '0;
    logic        lk_hit, lk_idx, lk_global;
    logic [55:0] lk_paddr, lk_pte_addr;
    logic [63:0] lk_pte;
    logic [1:0]  lk_level;
    logic        fill_en = 1'b0, fill_global = 1'b0;
    logic [15:0] fill_asid = '0;
    logic [38:0] fill_vaddr = '0;
    logic [55:0] fill_paddr = '0, fill_pte_addr = '0;
    logic [63:0] fill_pte = '0;
    logic [1:0]  fill_level = '0;
    logic        upd_en = 1'b0;
    logic [63:0] upd_pte = '0;
    logic        flush_en = 1'b0, flush_use_asid = 1'b0, flush_use_addr = 1'b0;
    logic [15:0] flush_asid = '0;
    logic [38:0] flush_vaddr = '0;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [38:0] VA  = 39'h00_1234_5678;
    localparam logic [55:0] PA  = 56'h00_0000_12_3456_7890;
    localparam logic [63:0] PT1 = 64'hDEAD_BEEF_0000_00CF;
    localparam logic [63:0] PT2 = 64'h0123_4567_89AB_CDEF;
    localparam logic [55:0] PTA = 56'h80_0000_1008;

    typedef struct packed {
        logic [15:0] asid;
        logic [38:0] va;
        logic        hit;
        logic [55:0] pa;
    } vec_t;

    // Lookups against a level-1 (2 MiB) entry: ID 5, address VA
    localparam vec_t VECS [5] = '{
        '{16'h0005, 39'h00_1234_5678, 1'b1, 56'h12_3454_5678},
        '{16'h0005, 39'h00_122B_A987, 1'b1, 56'h12_344B_A987},
        '{16'h0005, 39'h00_1214_5678, 1'b0, 56'h0},
        '{16'h0005, 39'h40_1234_5678, 1'b0, 56'h0},
        '{16'h0006, 39'h00_1234_5678, 1'b0, 56'h0}
    };

    tlb1_cache u_dut (.*);

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_fill(input logic [15:0] a, input logic g, input logic [38:0] v,
                           input logic [55:0] p, input logic [1:0] l);
        @(negedge clk);
        fill_en = 1'b1; fill_asid = a; fill_global = g; fill_vaddr = v;
        fill_paddr = p; fill_pte = PT1; fill_pte_addr = PTA; fill_level = l;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic do_flush(input logic ua, input logic [15:0] a, input logic uv,
                            input logic [38:0] v);
        @(negedge clk);
        flush_en = 1'b1; flush_use_asid = ua; flush_asid = a;
        flush_use_addr = uv; flush_vaddr = v;
        @(negedge clk);
        flush_en = 1'b0;
    endtask

    task automatic do_upd(input logic [63:0] p);
        @(negedge clk);
        upd_en = 1'b1; upd_pte = p;
        @(negedge clk);
        upd_en = 1'b0;
    endtask

    task automatic look(input logic [15:0] a, input logic [38:0] v);
        lk_asid = a; lk_vaddr = v;
        #1;
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        look(16'h5, VA);
        chk("R1 empty after reset", 64'(lk_hit), 64'd0);

        // R2: fill then read back fields
        do_fill(16'h5, 1'b0, VA, PA, 2'd1);
        look(16'h5, VA);
        chk("R2 hit", 64'(lk_hit), 64'd1);
        chk("R2 pte", lk_pte, PT1);
        chk("R2 pte_addr", 64'(lk_pte_addr), 64'(PTA));
        chk("R2 level", 64'(lk_level), 64'd1);
        chk("R2 global", 64'(lk_global), 64'd0);
        chk("R6 idx", 64'(lk_idx), 64'd0);

        // R3 R4 R5: table walk
        for (int i = 0; i < 5; i++) begin
            look(VECS[i].asid, VECS[i].va);
            chk("R3/R4 hit", 64'(lk_hit), 64'(VECS[i].hit));
            if (VECS[i].hit)
                chk("R5 paddr", 64'(lk_paddr), 64'(VECS[i].pa));
        end

        // R7: rewrite on live entry
        do_upd(PT2);
        look(16'h5, VA);
        chk("R7 pte rewritten", lk_pte, PT2);
        chk("R7 pte_addr kept", 64'(lk_pte_addr), 64'(PTA));
        chk("R7 still hit", 64'(lk_hit), 64'd1);

        // R11: non-matching flushes
        do_flush(1'b1, 16'h6, 1'b0, '0);
        look(16'h5, VA);
        chk("R11 other id kept", 64'(lk_hit), 64'd1);
        do_flush(1'b0, '0, 1'b1, VA ^ (39'd1 << 21));
        look(16'h5, VA);
        chk("R11 other page kept", 64'(lk_hit), 64'd1);

        // R10: address inside page
        do_flush(1'b0, '0, 1'b1, VA ^ 39'h0FFF);
        look(16'h5, VA);
        chk("R10 in-page flush", 64'(lk_hit), 64'd0);

        // R7: rewrite on empty entry stays empty
        do_upd(PT2);
        look(16'h5, VA);
        chk("R7 empty stays empty", 64'(lk_hit), 64'd0);

        // R9: ID flush on non-global
        do_fill(16'h5, 1'b0, VA, PA, 2'd1);
        do_flush(1'b1, 16'h5, 1'b0, '0);
        look(16'h5, VA);
        chk("R9 id flush", 64'(lk_hit), 64'd0);

        // R3: global ignores ID; R9 global survives ID flush; R8 flush all
        do_fill(16'h5, 1'b1, VA, PA, 2'd1);
        look(16'h77, VA);
        chk("R3 global any id", 64'(lk_hit), 64'd1);
        do_flush(1'b1, 16'h77, 1'b0, '0);
        look(16'h77, VA);
        chk("R9 global survives", 64'(lk_hit), 64'd1);
        do_flush(1'b0, '0, 1'b0, '0);
        look(16'h77, VA);
        chk("R8 flush all", 64'(lk_hit), 64'd0);

        // R4: level-0 boundary
        do_fill(16'h5, 1'b0, VA, PA, 2'd0);
        look(16'h5, VA ^ (39'd1 << 12));
        chk("R4 lvl0 bit12", 64'(lk_hit), 64'd0);
        look(16'h5, VA ^ (39'd1 << 11));
        chk("R4 lvl0 bit11", 64'(lk_hit), 64'd1);
        chk("R5 lvl0 paddr", 64'(lk_paddr), 64'h12_3456_7E78);

        // R4: level-2 boundary
        do_fill(16'h5, 1'b0, VA, PA, 2'd2);
        look(16'h5, VA ^ (39'd1 << 29));
        chk("R4 lvl2 bit29", 64'(lk_hit), 64'd1);
        look(16'h5, VA ^ (39'd1 << 30));
        chk("R4 lvl2 bit30", 64'(lk_hit), 64'd0);

        // R12: fill beats flush
        @(negedge clk);
        fill_en = 1'b1; fill_asid = 16'h9; fill_global = 1'b0; fill_vaddr = VA;
        fill_paddr = PA; fill_pte = PT1; fill_pte_addr = PTA; fill_level = 2'd1;
        flush_en = 1'b1; flush_use_asid = 1'b0; flush_use_addr = 1'b0;
        @(negedge clk);
        fill_en = 1'b0; flush_en = 1'b0;
        look(16'h9, VA);
        chk("R12 fill over flush", 64'(lk_hit), 64'd1);

        // R12: flush beats rewrite
        @(negedge clk);
        flush_en = 1'b1; upd_en = 1'b1; upd_pte = PT2;
        @(negedge clk);
        flush_en = 1'b0; upd_en = 1'b0;
        look(16'h9, VA);
        chk("R12 flush over rewrite", 64'(lk_hit), 64'd0);

        // R1: reset pulse clears a live entry
        do_fill(16'h5, 1'b0, VA, PA, 2'd1);
        do_reset();
        look(16'h5, VA);
        chk("R1 reset pulse", 64'(lk_hit), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule